// File: doc/BRIEF.md
# Time-of-Day Clock Register File

This block is the software-visible register file of a time-of-day clock. It offers four byte-wide ports. One index/data pair reaches a lower bank of clock and control registers. A second index/data pair reaches an upper bank of general storage. Software writes an index byte and can then read the selected byte back through the matching data port. Software can also write through that data port.

The time itself comes in from outside on a bus of separate fields: seconds, minutes, hours, weekday, day of month, month and year. Whenever software selects one of the low clock indices, the block samples those fields and writes them into the time registers. The format of that write follows two control bits: binary or two-digit BCD, and 24-hour or 12-hour with a PM flag. The same selection marks the contents as valid.

The block also keeps three status behaviours.
- A status register clears itself once it has been selected.
- A control write with the periodic-enable bit set makes that status register show every flag as fired.
- An update-in-progress flag rises after a parameterised number of clock-index selections, then stays high for a parameterised number of further selections.

Top module: `rtc_regfile`

## Requirements
- R1: After reset all four port latches read 0x00, and every register in both banks is 0x00.
- R2: A write to port 0 stores the whole byte, which then reads back on port 0. In the same cycle port 1 is loaded with lower-bank byte number (data & 0x7F). When that index is refreshed in the same access, port 1 is loaded with the refreshed value.
- R3: A write to port 1 stores the byte into the lower bank at (port0 & 0x7F), and port 1 reads back the written byte.
- R4: A write to port 2 stores the byte and loads port 3 with upper-bank byte number (data & 0x7F). A write to port 3 stores the byte into the upper bank at (port2 & 0x7F). The upper bank is separate from the lower bank.
- R5: A port-0 write whose low 7 bits are below 14 refreshes the time registers from the time inputs. The offsets are:
  - 0: seconds
  - 2: minutes
  - 4: hours
  - 6: weekday input + 1
  - 7: day of month
  - 8: month input + 1
  - 9: year input mod 100

  When bit 2 of register 0x0B is 1, the values are stored in binary.
- R6: When bit 2 of register 0x0B is 0, each refreshed value is stored as BCD: tens digit in bits 7:4, ones digit in bits 3:0.
- R7: When bit 1 of register 0x0B is 1, hours are stored as 0 to 23. When it is 0, the stored hour is (hour mod 12), with bit 7 set for hours 12 to 23.
- R8: A refreshing index write sets register 0x0D to 0x80.
- R9: A port-0 write whose low 7 bits equal 0x0C loads port 1 with the current value of register 0x0C, and then clears that register to 0x00.
- R10: A port-1 write while port 0 selects 0x0B, with data bit 6 set, also sets register 0x0C to 0xF0. With bit 6 clear, register 0x0C is left unchanged.
- R11: Bit 7 of register 0x0A (the update flag) counts refreshing index writes while it is clear, and it rises on the RISE_COUNT-th such write. Index writes of 14 or above do not count.
- R12: Once the flag has risen, the HOLD_COUNT-th refreshing index write clears it. Counting towards the next rise then restarts from zero.
- R13: Cycles without a write change no port latch and no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Port select: 0 lower index, 1 lower data, 2 upper index, 3 upper data |
| bus_wr | input | 1 | Write strobe for the selected port |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Latch of the selected port (combinational) |
| tm_sec | input | 6 | Seconds, 0 to 59 |
| tm_min | input | 6 | Minutes, 0 to 59 |
| tm_hour | input | 5 | Hours, 0 to 23 |
| tm_wday | input | 3 | Weekday, 0 to 6 |
| tm_mday | input | 5 | Day of month, 1 to 31 |
| tm_mon | input | 4 | Month, 0 to 11 |
| tm_year | input | 8 | Years since a base year, 0 to 255 |

## Verification
The assertions assume that at most one port access happens per cycle. They also assume the time fields stay within their stated ranges, so that every BCD digit fits in a nibble. The bench drives exactly one write strobe per access and leaves the bus idle between accesses. The time inputs are changed only while the bus is idle, and only to legal values. The update-flag checks run after a fresh reset, so the expected rise and fall positions are known exactly.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
   localparam int NUM_TIME_FIELDS = 7;
   localparam int HOUR_FIELD      = 2;
   localparam int REG_A           = 10;
   localparam int REG_B           = 11;
   localparam int REG_C           = 12;
   localparam int REG_D           = 13;
   localparam int REFRESH_LIMIT   = 14;
   localparam logic [7:0] VALID_MARK = 8'h80;
   localparam logic [7:0] ALL_FIRED  = 8'hF0;
   localparam int CTRL_BIN_BIT    = 2;
   localparam int CTRL_24H_BIT    = 1;
   localparam int CTRL_PIE_BIT    = 6;
   // Lower-bank offset of each time field, field 0 first.
   localparam logic [NUM_TIME_FIELDS-1:0][7:0] TIME_OFS =
      {8'd9, 8'd8, 8'd7, 8'd6, 8'd4, 8'd2, 8'd0};

   typedef enum logic [1:0] {
      P_LO_IDX = 2'd0,
      P_LO_DAT = 2'd1,
      P_HI_IDX = 2'd2,
      P_HI_DAT = 2'd3
   } port_e;
endpackage

// File: rtl/rtc_field_enc.sv
module rtc_field_enc (
   input  logic [6:0] val,
   input  logic       pm,
   input  logic       bin_mode,
   output logic [7:0] enc
);
   logic [3:0] tens;
   logic [3:0] ones;
   logic [7:0] base;

   assign tens = 4'(val / 7'd10);
   assign ones = 4'(val % 7'd10);
   assign base = bin_mode ? {1'b0, val} : {tens, ones};
   assign enc  = {base[7] | pm, base[6:0]};
endmodule

// File: rtl/rtc_time_fmt.sv
module rtc_time_fmt
   import rtc_pkg::*;
(
   input  logic [5:0] tm_sec,
   input  logic [5:0] tm_min,
   input  logic [4:0] tm_hour,
   input  logic [2:0] tm_wday,
   input  logic [4:0] tm_mday,
   input  logic [3:0] tm_mon,
   input  logic [7:0] tm_year,
   input  logic       bin_mode,
   input  logic       mode_24h,
   output logic [NUM_TIME_FIELDS-1:0][7:0] time_bytes
);
   logic [NUM_TIME_FIELDS-1:0][6:0] raw;
   logic       is_pm;
   logic [4:0] hour12;
   logic       pm_flag;

   assign is_pm   = (tm_hour >= 5'd12);
   assign hour12  = is_pm ? (tm_hour - 5'd12) : tm_hour;
   assign pm_flag = is_pm & ~mode_24h;

   always_comb begin
      raw[0] = {1'b0, tm_sec};
      raw[1] = {1'b0, tm_min};
      raw[HOUR_FIELD] = mode_24h ? {2'b00, tm_hour} : {2'b00, hour12};
      raw[3] = {4'b0000, tm_wday} + 7'd1;
      raw[4] = {2'b00, tm_mday};
      raw[5] = {3'b000, tm_mon} + 7'd1;
      raw[6] = 7'(tm_year % 8'd100);
   end

   for (genvar k = 0; k < NUM_TIME_FIELDS; k++) begin : g_field
      if (k == HOUR_FIELD) begin : g_hour
         rtc_field_enc u_enc (
            .val(raw[k]), .pm(pm_flag), .bin_mode(bin_mode), .enc(time_bytes[k]));
      end else begin : g_plain
         rtc_field_enc u_enc (
            .val(raw[k]), .pm(1'b0), .bin_mode(bin_mode), .enc(time_bytes[k]));
      end
   end
endmodule

// File: rtl/rtc_uip_ctrl.sv
module rtc_uip_ctrl #(
   parameter int RISE_COUNT = 4,
   parameter int HOLD_COUNT = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic flag,
   output logic uip_set,
   output logic uip_clr
);
   localparam int RC_W = $clog2(RISE_COUNT + 1);
   localparam int HC_W = $clog2(HOLD_COUNT + 1);
   localparam logic [RC_W-1:0] RISE_LAST = RC_W'(RISE_COUNT - 1);
   localparam logic [HC_W-1:0] HOLD_LOAD = HC_W'(HOLD_COUNT);

   logic [RC_W-1:0] rise_cnt;
   logic [HC_W-1:0] hold_cnt;

   initial begin
      assert (RISE_COUNT >= 1) else $error("RISE_COUNT must be at least 1");
      assert (HOLD_COUNT >= 1) else $error("HOLD_COUNT must be at least 1");
   end

   assign uip_set = tick && !flag && (rise_cnt == RISE_LAST);
   assign uip_clr = tick && flag && (hold_cnt <= HC_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rise_cnt <= '0;
         hold_cnt <= '0;
      end else if (tick) begin
         if (flag) begin
            if (uip_clr) begin
               hold_cnt <= '0;
               rise_cnt <= '0;
            end else begin
               hold_cnt <= hold_cnt - HC_W'(1);
            end
         end else if (uip_set) begin
            rise_cnt <= '0;
            hold_cnt <= HOLD_LOAD;
         end else begin
            rise_cnt <= rise_cnt + RC_W'(1);
         end
      end
   end
endmodule

// File: rtl/rtc_regbank.sv
module rtc_regbank
   import rtc_pkg::*;
#(
   parameter int IDX_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             refresh,
   input  logic [NUM_TIME_FIELDS-1:0][7:0] time_bytes,
   input  logic             uip_set,
   input  logic             uip_clr,
   input  logic             c_clear,
   input  logic             lo_wr_en,
   input  logic [IDX_W-1:0] lo_wr_idx,
   input  logic [7:0]       lo_wr_data,
   input  logic             c_fire,
   input  logic [IDX_W-1:0] lo_rd_idx,
   output logic [7:0]       lo_rd_view,
   input  logic             hi_wr_en,
   input  logic [IDX_W-1:0] hi_wr_idx,
   input  logic [7:0]       hi_wr_data,
   input  logic [IDX_W-1:0] hi_rd_idx,
   output logic [7:0]       hi_rd_data,
   output logic [7:0]       ctrl_b,
   output logic             flag_a,
   output logic [7:0]       reg_c,
   output logic [7:0]       reg_d
);
   localparam int DEPTH = 1 << IDX_W;
   localparam logic [IDX_W-1:0] A_I = IDX_W'(REG_A);
   localparam logic [IDX_W-1:0] B_I = IDX_W'(REG_B);
   localparam logic [IDX_W-1:0] C_I = IDX_W'(REG_C);
   localparam logic [IDX_W-1:0] D_I = IDX_W'(REG_D);

   logic [7:0] lo_mem [DEPTH];
   logic [7:0] hi_mem [DEPTH];
   logic       flag_next;

   assign flag_next = uip_set ? 1'b1 : (uip_clr ? 1'b0 : lo_mem[A_I][7]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) begin
            lo_mem[i] <= '0;
            hi_mem[i] <= '0;
         end
      end else begin
         if (refresh) begin
            for (int k = 0; k < NUM_TIME_FIELDS; k++)
               lo_mem[TIME_OFS[k][IDX_W-1:0]] <= time_bytes[k];
            lo_mem[D_I]    <= VALID_MARK;
            lo_mem[A_I][7] <= flag_next;
         end
         if (c_clear)
            lo_mem[C_I] <= '0;
         if (lo_wr_en) begin
            lo_mem[lo_wr_idx] <= lo_wr_data;
            if (c_fire)
               lo_mem[C_I] <= ALL_FIRED;
         end
         if (hi_wr_en)
            hi_mem[hi_wr_idx] <= hi_wr_data;
      end
   end

   // Post-update view of the byte that an index write selects.
   always_comb begin
      lo_rd_view = lo_mem[lo_rd_idx];
      if (refresh) begin
         for (int k = 0; k < NUM_TIME_FIELDS; k++)
            if (lo_rd_idx == TIME_OFS[k][IDX_W-1:0])
               lo_rd_view = time_bytes[k];
         if (lo_rd_idx == D_I)
            lo_rd_view = VALID_MARK;
         if (lo_rd_idx == A_I)
            lo_rd_view = {flag_next, lo_mem[A_I][6:0]};
      end
   end

   assign hi_rd_data = hi_mem[hi_rd_idx];
   assign ctrl_b     = lo_mem[B_I];
   assign flag_a     = lo_mem[A_I][7];
   assign reg_c      = lo_mem[C_I];
   assign reg_d      = lo_mem[D_I];
endmodule

// File: rtl/rtc_regfile.sv
module rtc_regfile
   import rtc_pkg::*;
#(
   parameter int IDX_W      = 7,
   parameter int RISE_COUNT = 4,
   parameter int HOLD_COUNT = 3
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] bus_addr,
   input  logic       bus_wr,
   input  logic [7:0] bus_wdata,
   output logic [7:0] bus_rdata,
   input  logic [5:0] tm_sec,
   input  logic [5:0] tm_min,
   input  logic [4:0] tm_hour,
   input  logic [2:0] tm_wday,
   input  logic [4:0] tm_mday,
   input  logic [3:0] tm_mon,
   input  logic [7:0] tm_year
);
   localparam logic [IDX_W-1:0] B_I     = IDX_W'(REG_B);
   localparam logic [IDX_W-1:0] C_I     = IDX_W'(REG_C);
   localparam logic [IDX_W-1:0] LIMIT_I = IDX_W'(REFRESH_LIMIT);

   initial begin
      assert (IDX_W >= 4 && IDX_W <= 7) else $error("IDX_W must be 4 to 7");
   end

   logic [7:0] idx_lo, lat_lo, idx_hi, lat_hi;
   logic       wr_lo_idx, wr_lo_dat, wr_hi_idx, wr_hi_dat;
   logic       refresh, c_clear, c_fire;
   logic       uip_set, uip_clr, flag_a;
   logic [7:0] lo_rd_view, hi_rd_data, ctrl_b, reg_c_q, reg_d_q;
   logic [NUM_TIME_FIELDS-1:0][7:0] time_bytes;
   logic [IDX_W-1:0] wsel;

   assign wsel      = bus_wdata[IDX_W-1:0];
   assign wr_lo_idx = bus_wr && (bus_addr == P_LO_IDX);
   assign wr_lo_dat = bus_wr && (bus_addr == P_LO_DAT);
   assign wr_hi_idx = bus_wr && (bus_addr == P_HI_IDX);
   assign wr_hi_dat = bus_wr && (bus_addr == P_HI_DAT);
   assign refresh   = wr_lo_idx && (wsel < LIMIT_I);
   assign c_clear   = wr_lo_idx && (wsel == C_I);
   assign c_fire    = wr_lo_dat && (idx_lo[IDX_W-1:0] == B_I) && bus_wdata[CTRL_PIE_BIT];

   rtc_time_fmt u_fmt (
      .tm_sec(tm_sec), .tm_min(tm_min), .tm_hour(tm_hour), .tm_wday(tm_wday),
      .tm_mday(tm_mday), .tm_mon(tm_mon), .tm_year(tm_year),
      .bin_mode(ctrl_b[CTRL_BIN_BIT]), .mode_24h(ctrl_b[CTRL_24H_BIT]),
      .time_bytes(time_bytes));

   rtc_uip_ctrl #(.RISE_COUNT(RISE_COUNT), .HOLD_COUNT(HOLD_COUNT)) u_uip (
      .clk(clk), .rst_n(rst_n), .tick(refresh), .flag(flag_a),
      .uip_set(uip_set), .uip_clr(uip_clr));

   rtc_regbank #(.IDX_W(IDX_W)) u_bank (
      .clk(clk), .rst_n(rst_n), .refresh(refresh), .time_bytes(time_bytes),
      .uip_set(uip_set), .uip_clr(uip_clr), .c_clear(c_clear),
      .lo_wr_en(wr_lo_dat), .lo_wr_idx(idx_lo[IDX_W-1:0]), .lo_wr_data(bus_wdata),
      .c_fire(c_fire), .lo_rd_idx(wsel), .lo_rd_view(lo_rd_view),
      .hi_wr_en(wr_hi_dat), .hi_wr_idx(idx_hi[IDX_W-1:0]), .hi_wr_data(bus_wdata),
      .hi_rd_idx(wsel), .hi_rd_data(hi_rd_data),
      .ctrl_b(ctrl_b), .flag_a(flag_a), .reg_c(reg_c_q), .reg_d(reg_d_q));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_lo <= '0;
         lat_lo <= '0;
         idx_hi <= '0;
         lat_hi <= '0;
      end else begin
         if (wr_lo_idx) begin
            idx_lo <= bus_wdata;
            lat_lo <= lo_rd_view;
         end
         if (wr_lo_dat)
            lat_lo <= bus_wdata;
         if (wr_hi_idx) begin
            idx_hi <= bus_wdata;
            lat_hi <= hi_rd_data;
         end
         if (wr_hi_dat)
            lat_hi <= bus_wdata;
      end
   end

   always_comb begin
      unique case (bus_addr)
         P_LO_IDX: bus_rdata = idx_lo;
         P_LO_DAT: bus_rdata = lat_lo;
         P_HI_IDX: bus_rdata = idx_hi;
         default:  bus_rdata = lat_hi;
      endcase
   end
endmodule

// File: rtl/rtc_regfile_chk.sv
module rtc_regfile_chk #(
   parameter int IDX_W = 7
) (
   input logic       clk,
   input logic       rst_n,
   input logic [1:0] bus_addr,
   input logic       bus_wr,
   input logic [7:0] bus_wdata,
   input logic [7:0] idx_lo,
   input logic [7:0] lat_lo,
   input logic [7:0] idx_hi,
   input logic [7:0] lat_hi,
   input logic       uip_flag,
   input logic [7:0] reg_c,
   input logic [7:0] reg_d
);
   logic qual_idx, wr_a;
   assign qual_idx = bus_wr && bus_addr == 2'd0 && bus_wdata[IDX_W-1:0] < IDX_W'(14);
   assign wr_a     = bus_wr && bus_addr == 2'd1 && idx_lo[IDX_W-1:0] == IDX_W'(10);

   p_idx_echo_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == 2'd0) |=> idx_lo == $past(bus_wdata));

   p_valid_mark_r8: assert property (@(posedge clk) disable iff (!rst_n)
      qual_idx |=> reg_d == 8'h80);

   p_c_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == 2'd0 && bus_wdata[IDX_W-1:0] == IDX_W'(12)) |=> reg_c == 8'h00);

   p_c_fire_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == 2'd1 && idx_lo[IDX_W-1:0] == IDX_W'(11) && bus_wdata[6])
      |=> reg_c == 8'hF0);

   p_uip_rise_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(uip_flag) |-> ($past(qual_idx) || $past(wr_a)));

   p_uip_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (!qual_idx && !wr_a) |=> $stable(uip_flag));

   p_idle_latches_r13: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_wr |=> ($stable(idx_lo) && $stable(lat_lo) && $stable(idx_hi) && $stable(lat_hi)));

   p_idle_status_r13: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_wr |=> ($stable(reg_c) && $stable(reg_d)));
endmodule

bind rtc_regfile rtc_regfile_chk #(.IDX_W(IDX_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
   .idx_lo(idx_lo), .lat_lo(lat_lo), .idx_hi(idx_hi), .lat_hi(lat_hi),
   .uip_flag(flag_a), .reg_c(reg_c_q), .reg_d(reg_d_q));

// File: tb/rtc_regfile_test.sv
module rtc_regfile_test;
   localparam int CLK_PERIOD = 10;
   localparam int RISE = 4;
   localparam int HOLD = 3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] bus_addr = '0;
   logic       bus_wr = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic [5:0] tm_sec = '0;
   logic [5:0] tm_min = '0;
   logic [4:0] tm_hour = '0;
   logic [2:0] tm_wday = '0;
   logic [4:0] tm_mday = 5'd1;
   logic [3:0] tm_mon = '0;
   logic [7:0] tm_year = '0;

   int checks = 0;
   int failures = 0;
   int mbank [256];
   int mlat [4];
   int m_rc, m_hc;

   always #(CLK_PERIOD/2) clk = ~clk;

   rtc_regfile #(.IDX_W(7), .RISE_COUNT(RISE), .HOLD_COUNT(HOLD)) uut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tm_sec(tm_sec), .tm_min(tm_min),
      .tm_hour(tm_hour), .tm_wday(tm_wday), .tm_mday(tm_mday), .tm_mon(tm_mon),
      .tm_year(tm_year));

   task automatic check(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
      end
   endtask

   function automatic int fmt(int v, bit bin);
      return bin ? v : (((v / 10) << 4) | (v % 10));
   endfunction

   task automatic model_reset();
      for (int i = 0; i < 256; i++) mbank[i] = 0;
      for (int i = 0; i < 4; i++) mlat[i] = 0;
      m_rc = 0;
      m_hc = 0;
   endtask

   task automatic model_uip();
      if ((mbank[10] & 128) != 0) begin
         if (m_hc <= 1) begin
            mbank[10] &= 127;
            m_hc = 0;
            m_rc = 0;
         end else m_hc--;
      end else if (m_rc == RISE - 1) begin
         mbank[10] |= 128;
         m_hc = HOLD;
         m_rc = 0;
      end else m_rc++;
   endtask

   task automatic model_op(int p, int d);
      int i;
      bit bin, h24;
      case (p)
         0: begin
            i = d & 127;
            if (i < 14) begin
               bin = mbank[11][2];
               h24 = mbank[11][1];
               mbank[0] = fmt(tm_sec, bin);
               mbank[2] = fmt(tm_min, bin);
               if (h24) mbank[4] = fmt(tm_hour, bin);
               else mbank[4] = ((tm_hour >= 12) ? 128 : 0) | fmt(tm_hour % 12, bin);
               mbank[6] = fmt(tm_wday + 1, bin);
               mbank[7] = fmt(tm_mday, bin);
               mbank[8] = fmt(tm_mon + 1, bin);
               mbank[9] = fmt(tm_year % 100, bin);
               mbank[13] = 128;
               model_uip();
            end
            mlat[0] = d;
            mlat[1] = mbank[i];
            if (i == 12) mbank[12] = 0;
         end
         1: begin
            i = mlat[0] & 127;
            if (i == 11 && (d & 64) != 0) mbank[12] = 240;
            mbank[i] = d;
            mlat[1] = d;
         end
         2: begin
            mlat[2] = d;
            mlat[3] = mbank[128 + (d & 127)];
         end
         default: begin
            mbank[128 + (mlat[2] & 127)] = d;
            mlat[3] = d;
         end
      endcase
   endtask

   task automatic compare_all(string tag);
      for (int q = 0; q < 4; q++) begin
         bus_addr = q[1:0];
         #1;
         check(tag, bus_rdata, mlat[q]);
      end
   endtask

   task automatic op(int p, int d, string tag);
      @(negedge clk);
      bus_addr = p[1:0];
      bus_wdata = d[7:0];
      bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
      model_op(p, d);
      compare_all(tag);
   endtask

   task automatic expect_port(int p, int exp, string tag);
      bus_addr = p[1:0];
      #1;
      check(tag, bus_rdata, exp);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      model_reset();
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      model_reset();
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      compare_all("R1 reset latches");
      for (int q = 0; q < 4; q++) expect_port(q, 0, "R1 reset zero");

      tm_sec = 6'd27; tm_min = 6'd45; tm_hour = 5'd13; tm_wday = 3'd3;
      tm_mday = 5'd29; tm_mon = 4'd10; tm_year = 8'd124;

      // binary, 24-hour
      op(0, 8'h0B, "R5 select ctrl");
      op(1, 8'h06, "R3 ctrl write");
      op(0, 8'h00, "R5"); expect_port(1, 27, "R5 seconds bin");
      op(0, 8'h02, "R5"); expect_port(1, 45, "R5 minutes bin");
      op(0, 8'h04, "R5"); expect_port(1, 13, "R7 hours 24h bin");
      op(0, 8'h06, "R5"); expect_port(1, 4,  "R5 weekday+1");
      op(0, 8'h07, "R5"); expect_port(1, 29, "R5 mday");
      op(0, 8'h08, "R5"); expect_port(1, 11, "R5 month+1");
      op(0, 8'h09, "R5"); expect_port(1, 24, "R5 year mod 100");
      op(0, 8'h0D, "R8"); expect_port(1, 8'h80, "R8 valid mark");

      // BCD, 24-hour
      op(0, 8'h0B, "R6"); op(1, 8'h02, "R6");
      op(0, 8'h04, "R6"); expect_port(1, 8'h13, "R6 hours bcd");
      op(0, 8'h00, "R6"); expect_port(1, 8'h27, "R6 seconds bcd");
      op(0, 8'h09, "R6"); expect_port(1, 8'h24, "R6 year bcd");

      // BCD, 12-hour
      op(0, 8'h0B, "R7"); op(1, 8'h00, "R7");
      op(0, 8'h04, "R7"); expect_port(1, 8'h81, "R7 pm bcd");
      tm_hour = 5'd9;
      op(0, 8'h04, "R7"); expect_port(1, 8'h09, "R7 am bcd");
      tm_hour = 5'd23;
      op(0, 8'h04, "R7"); expect_port(1, 8'h91, "R7 pm 11 bcd");
      // binary, 12-hour
      op(0, 8'h0B, "R7"); op(1, 8'h04, "R7");
      op(0, 8'h04, "R7"); expect_port(1, 8'h8B, "R7 pm 11 bin");

      // self-clearing status
      op(0, 8'h0C, "R9"); op(1, 8'h5A, "R9 store");
      op(0, 8'h0C, "R9"); expect_port(1, 8'h5A, "R9 old value");
      op(0, 8'h0C, "R9"); expect_port(1, 8'h00, "R9 cleared");

      // periodic-enable forces status
      op(0, 8'h0B, "R10"); op(1, 8'h46, "R10");
      op(0, 8'h0C, "R10"); expect_port(1, 8'hF0, "R10 fired");
      op(0, 8'h0B, "R10"); op(1, 8'h06, "R10");
      op(0, 8'h0C, "R10"); expect_port(1, 8'h00, "R10 no fire");

      // general lower-bank storage and full index byte
      op(0, 8'h20, "R3"); op(1, 8'h3C, "R3");
      op(0, 8'h21, "R3"); op(1, 8'hC3, "R3");
      op(0, 8'hA0, "R2"); expect_port(0, 8'hA0, "R2 full index");
      expect_port(1, 8'h3C, "R2 masked select");

      // upper bank
      op(2, 8'h20, "R4"); expect_port(3, 8'h00, "R4 separate bank");
      op(3, 8'h77, "R4"); op(2, 8'h05, "R4"); op(3, 8'h11, "R4");
      op(2, 8'hA0, "R4"); expect_port(3, 8'h77, "R4 masked upper");
      op(2, 8'h05, "R4"); expect_port(3, 8'h11, "R4 readback");

      // idle cycles leave everything alone
      op(0, 8'h0B, "R13"); op(1, 8'h46, "R13");
      op(0, 8'h21, "R13");
      repeat (6) @(negedge clk);
      compare_all("R13 idle");
      expect_port(1, 8'hC3, "R13 data held");

      // update flag after a fresh reset
      do_reset();
      compare_all("R1 second reset");
      for (int n = 0; n < 3; n++) op(0, 8'h30, "R11 non-counting");
      for (int n = 1; n <= 11; n++) begin
         op(0, 8'h0A, "R11/R12 flag");
         if (n >= 4 && n <= 6) expect_port(1, 8'h80, "R12 flag high");
         else if (n == 11) expect_port(1, 8'h80, "R11 rise again");
         else if (n < 4) expect_port(1, 8'h00, "R11 not yet");
         else expect_port(1, 8'h00, "R12 flag cleared");
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule